// File: doc/BRIEF.md
# Memory-Mapped Parallel I/O Port with Edge Capture

This block is a general-purpose parallel I/O port of 1 to 32 pins, driven by a host over a simple word-addressed register bus (address, read strobe, write strobe, write data, read data). The host loads an output register that drives the pins. A per-bit direction register drives each pin's output enable. The host also reads back the input pins after a two-flop synchronizer.

Each synchronized input is compared with its previous sample to find edges. The edge kind (rising, falling or either) is fixed by a parameter. Detected edges are latched into a capture register, and the host clears that register either bit by bit or all at once. A mask register selects which bits may raise the single interrupt output. A parameter selects the interrupt source: either the synchronized input levels or the captured edges. Two write-only aliases let the host set or clear chosen output bits without a read-modify-write.

Top module: `gpio_edge_port`

## Requirements
- R1: After a synchronous active-low reset, the output register, direction register, mask register and capture register are all zero, and `irq` is low.
- R2: A write to word offset 0 loads `pin_out`. A read of offset 0 returns `pin_in` as sampled by two clock edges. The new value is visible after the second rising edge that follows a pin change, and not after the first.
- R3: A write to offset 1 loads the direction register, which drives `pin_oe`. A bit of 1 drives the pin and a bit of 0 tri-states it. The direction register reads back at offset 1 and changes only on such a write.
- R4: Writing to offset 4 sets every output bit written as 1. Writing to offset 5 clears every output bit written as 1. All other output bits keep their values, and reads of offsets 4 and 5 return zero.
- R5: The capture register, read at offset 3, sets a bit when the configured edge occurs on that synchronized input. EDGE_KIND 0 selects rising edges, 1 selects falling edges and 2 selects both. The bit is set on the third rising clock edge after the pin change. A steady input never sets a bit again.
- R6: With BIT_CLEAR = 1, a write to offset 3 clears exactly the capture bits written as 1. For example, 0x4 clears bit 2 only.
- R7: With BIT_CLEAR = 0, any write to offset 3 clears every capture bit, whatever the data.
- R8: An edge detected in the same cycle as a write that clears its capture bit leaves that bit set.
- R9: With IRQ_ON_EDGE = 0, `irq` is registered and is high exactly when some synchronized input bit is 1 and its mask bit is 1. It is valid from the third rising edge after a pin change.
- R10: With IRQ_ON_EDGE = 1, `irq` is registered and is high exactly when some capture bit is 1 and its mask bit is 1. It follows the capture register by one cycle.
- R11: The mask register is written and read at offset 2. `irq` can only be high if the mask was nonzero in the previous cycle.
- R12: `rdata` is zero when `rd` is low, and its bits above WIDTH always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 3 | Register word offset |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr and rd |
| pin_in | input | WIDTH | Raw input pin levels |
| pin_out | output | WIDTH | Output register value |
| pin_oe | output | WIDTH | Per-pin output enable (1 drives) |
| irq | output | 1 | Registered active-high interrupt |

## Verification
The hardest case to reach from the ports is an edge that reaches the capture stage in exactly the cycle in which the host clears that bit. The stimulus changes the pins on a falling clock edge. It lets two rising edges pass for the synchronizer, then places the clearing write so that it lands on the third rising edge, when the edge is detected. Edge detection is also swept over every pair of old and new pin patterns on a four-bit port, and the interrupt logic is swept over every mask and pin pattern. Three instances with different edge, clear and interrupt settings share the same stimulus.

// File: rtl/gpio_pkg.sv
// Shared definitions for the parallel I/O port: edge kinds and register offsets.
package gpio_pkg;
    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_ANY  = 2'd2
    } edge_kind_e;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_DIR  = 3'd1;
    localparam logic [2:0] OFS_MASK = 3'd2;
    localparam logic [2:0] OFS_CAPT = 3'd3;
    localparam logic [2:0] OFS_SET  = 3'd4;
    localparam logic [2:0] OFS_CLR  = 3'd5;
endpackage

// File: rtl/gpio_in_sync.sv
// Input stage: two-flop synchronizer, plus a previous-sample flop for edge detection.
// Assumes pin_in is asynchronous to clk. The edge output is combinational from flops,
// so each edge is reported for exactly one cycle, right after it is synchronized.
module gpio_in_sync #(
    parameter int                     WIDTH     = 32,
    parameter gpio_pkg::edge_kind_e   EDGE_KIND = gpio_pkg::EDGE_RISE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] sample_o,
    output logic [WIDTH-1:0] edge_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    // Synchronize the pins and keep one older sample for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sample_o = sync_q;

    // Pick the edge detector that matches the configured edge kind.
    generate
        if (EDGE_KIND == gpio_pkg::EDGE_RISE) begin : g_rise
            assign edge_o = sync_q & ~prev_q;
        end else if (EDGE_KIND == gpio_pkg::EDGE_FALL) begin : g_fall
            assign edge_o = ~sync_q & prev_q;
        end else begin : g_any
            assign edge_o = sync_q ^ prev_q;
        end
    endgenerate
endmodule

// File: rtl/gpio_edge_cap.sv
// Edge-capture register. Sets bits on detected edges and clears them on host writes.
// With BIT_CLEAR=1 only the written ones are cleared; otherwise any write clears all.
// A new edge wins over a clear that hits the same bit in the same cycle.
module gpio_edge_cap #(
    parameter int WIDTH     = 32,
    parameter bit BIT_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] edge_i,
    input  logic             clr_stb,
    input  logic [WIDTH-1:0] clr_bits,
    output logic [WIDTH-1:0] cap_o
);
    logic [WIDTH-1:0] clr_mask;

    // Choose which bits the host write removes.
    generate
        if (BIT_CLEAR) begin : g_bitwise
            assign clr_mask = clr_stb ? clr_bits : '0;
        end else begin : g_all
            assign clr_mask = clr_stb ? {WIDTH{1'b1}} : '0;
        end
    endgenerate

    // Hold, clear and set the captured edges.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_o <= '0;
        else        cap_o <= (cap_o & ~clr_mask) | edge_i;
    end
endmodule

// File: rtl/gpio_irq_gen.sv
// Interrupt generator. Masks either input levels or captured edges, selected by
// IRQ_ON_EDGE, and registers the OR of the result as an active-high request.
module gpio_irq_gen #(
    parameter int WIDTH       = 32,
    parameter bit IRQ_ON_EDGE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] cap_i,
    input  logic [WIDTH-1:0] mask_i,
    output logic             irq_o
);
    logic [WIDTH-1:0] source;

    // Pick the interrupt source.
    generate
        if (IRQ_ON_EDGE) begin : g_edge
            assign source = cap_i;
        end else begin : g_level
            assign source = level_i;
        end
    endgenerate

    // Register the masked request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(source & mask_i);
    end
endmodule

// File: rtl/gpio_edge_port.sv
// Top of the parallel I/O port. Holds the output, direction and mask registers,
// decodes host writes and muxes host reads. Assumes single-cycle bus strobes and
// a combinational read path; wdata bits above WIDTH are ignored.
module gpio_edge_port #(
    parameter int                   WIDTH       = 32,
    parameter gpio_pkg::edge_kind_e EDGE_KIND   = gpio_pkg::EDGE_RISE,
    parameter bit                   BIT_CLEAR   = 1'b1,
    parameter bit                   IRQ_ON_EDGE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       addr,
    input  logic             rd,
    input  logic             wr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic             irq
);
    import gpio_pkg::*;

    localparam int DW = WIDTH;

    logic [DW-1:0] out_q;
    logic [DW-1:0] dir_q;
    logic [DW-1:0] mask_q;
    logic [DW-1:0] sample;
    logic [DW-1:0] edges;
    logic [DW-1:0] cap_q;
    logic [DW-1:0] wbits;
    logic          wr_data, wr_dir, wr_mask, wr_capt, wr_set, wr_clr;

    assign wbits   = wdata[DW-1:0];
    assign wr_data = wr && (addr == OFS_DATA);
    assign wr_dir  = wr && (addr == OFS_DIR);
    assign wr_mask = wr && (addr == OFS_MASK);
    assign wr_capt = wr && (addr == OFS_CAPT);
    assign wr_set  = wr && (addr == OFS_SET);
    assign wr_clr  = wr && (addr == OFS_CLR);

    gpio_in_sync #(.WIDTH(DW), .EDGE_KIND(EDGE_KIND)) in_sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .sample_o (sample),
        .edge_o   (edges)
    );

    gpio_edge_cap #(.WIDTH(DW), .BIT_CLEAR(BIT_CLEAR)) edge_cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_i   (edges),
        .clr_stb  (wr_capt),
        .clr_bits (wbits),
        .cap_o    (cap_q)
    );

    gpio_irq_gen #(.WIDTH(DW), .IRQ_ON_EDGE(IRQ_ON_EDGE)) irq_gen_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sample),
        .cap_i   (cap_q),
        .mask_i  (mask_q),
        .irq_o   (irq)
    );

    // Output register: full load, bitwise set and bitwise clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       out_q <= '0;
        else if (wr_data) out_q <= wbits;
        else if (wr_set)  out_q <= out_q | wbits;
        else if (wr_clr)  out_q <= out_q & ~wbits;
    end

    // Direction and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            mask_q <= '0;
        end else begin
            if (wr_dir)  dir_q  <= wbits;
            if (wr_mask) mask_q <= wbits;
        end
    end

    // Read mux; write-only and unused offsets return zero.
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                OFS_DATA: rdata[DW-1:0] = sample;
                OFS_DIR:  rdata[DW-1:0] = dir_q;
                OFS_MASK: rdata[DW-1:0] = mask_q;
                OFS_CAPT: rdata[DW-1:0] = cap_q;
                default:  rdata = '0;
            endcase
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_edge_port_chk.sv
// Checker for gpio_edge_port: temporal properties on the ports and on the
// mask and capture registers, attached to every instance by bind.
module gpio_edge_port_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       addr,
    input logic             rd,
    input logic             wr,
    input logic [31:0]      wdata,
    input logic [31:0]      rdata,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_oe,
    input logic             irq,
    input logic [WIDTH-1:0] mask_q,
    input logic [WIDTH-1:0] cap_q
);
    // R1: registers are empty on the first cycle after reset.
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_out == '0 && pin_oe == '0 && mask_q == '0 && cap_q == '0 && !irq));

    // R4: a set write ORs the data into the outputs.
    assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr) && $past(addr) == 3'd4)
        |-> pin_out == ($past(pin_out) | $past(wdata[WIDTH-1:0])));

    // R4: a clear write removes the written ones from the outputs.
    assert_clr_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr) && $past(addr) == 3'd5)
        |-> pin_out == ($past(pin_out) & ~$past(wdata[WIDTH-1:0])));

    // R4: write-only offsets read as zero.
    assert_wo_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr >= 3'd4) |-> rdata == 32'd0);

    // R3: the direction register only changes on its own write.
    assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(wr) && $past(addr) == 3'd1)) |-> pin_oe == $past(pin_oe));

    // R5: without a capture write no captured bit is lost.
    assert_cap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(wr) && $past(addr) == 3'd3))
        |-> (cap_q & $past(cap_q)) == $past(cap_q));

    // R11: the interrupt needs a nonzero mask one cycle earlier.
    assert_irq_needs_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && irq) |-> $past(mask_q) != '0);

    // R12: idle bus reads zero.
    assert_idle_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> rdata == 32'd0);
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.WIDTH(WIDTH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rd      (rd),
    .wr      (wr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq),
    .mask_q  (mask_q),
    .cap_q   (cap_q)
);

// File: tb/gpio_edge_port_tb_top.sv
`timescale 1ns/1ps
// Bench: three 4-bit instances share one bus and one set of pins.
// dut_i: rising edges, per-bit clear, edge irq. dut_fall_i: falling, clear-all,
// level irq. dut_any_i: both edges, per-bit clear, edge irq.
module gpio_edge_port_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   addr = '0;
    logic         rd = 1'b0;
    logic         wr = 1'b0;
    logic [31:0]  wdata = '0;
    logic [W-1:0] pin_in = '0;

    logic [31:0]  rdata_a, rdata_b, rdata_c;
    logic [W-1:0] out_a, out_b, out_c, oe_a, oe_b, oe_c;
    logic         irq_a, irq_b, irq_c;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    gpio_edge_port #(.WIDTH(W), .EDGE_KIND(gpio_pkg::EDGE_RISE), .BIT_CLEAR(1'b1), .IRQ_ON_EDGE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata_a),
        .pin_in(pin_in), .pin_out(out_a), .pin_oe(oe_a), .irq(irq_a));
    gpio_edge_port #(.WIDTH(W), .EDGE_KIND(gpio_pkg::EDGE_FALL), .BIT_CLEAR(1'b0), .IRQ_ON_EDGE(1'b0)) dut_fall_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata_b),
        .pin_in(pin_in), .pin_out(out_b), .pin_oe(oe_b), .irq(irq_b));
    gpio_edge_port #(.WIDTH(W), .EDGE_KIND(gpio_pkg::EDGE_ANY), .BIT_CLEAR(1'b1), .IRQ_ON_EDGE(1'b1)) dut_any_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata_c),
        .pin_in(pin_in), .pin_out(out_c), .pin_oe(oe_c), .irq(irq_c));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling clock edge.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick(1);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a);
        addr = a; rd = 1'b1;
        #1;
    endtask

    task automatic bus_idle();
        rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state.
        check("R1 pin_out", {28'd0, out_a}, 32'd0);
        check("R1 pin_oe", {28'd0, oe_a}, 32'd0);
        check("R1 irq", {31'd0, irq_a | irq_b | irq_c}, 32'd0);
        bus_read(3'd2); check("R1 mask", rdata_a, 32'd0);
        bus_read(3'd3); check("R1 capture", rdata_c, 32'd0);
        bus_idle();
        #1 check("R12 idle rdata", rdata_a | rdata_b | rdata_c, 32'd0);

        // R2: output load and synchronized input read.
        bus_write(3'd0, 32'hFFFF_FFF6);
        check("R2 pin_out load", {28'd0, out_b}, 32'h6);
        pin_in = 4'hA;
        tick(1);
        bus_read(3'd0); check("R2 input not yet visible", rdata_a, 32'h0); bus_idle();
        tick(1);
        bus_read(3'd0); check("R2 input after sync", rdata_a, 32'hA); bus_idle();
        pin_in = 4'h0;
        tick(3);

        // R3: direction register.
        bus_write(3'd1, 32'h9);
        check("R3 pin_oe", {28'd0, oe_c}, 32'h9);
        bus_read(3'd1); check("R3 dir readback", rdata_a, 32'h9); bus_idle();
        bus_write(3'd1, 32'h0);

        // R4: set and clear aliases.
        bus_write(3'd0, 32'h5);
        bus_write(3'd4, 32'h2);
        check("R4 set", {28'd0, out_a}, 32'h7);
        bus_write(3'd5, 32'h4);
        check("R4 clear", {28'd0, out_a}, 32'h3);
        bus_write(3'd4, 32'h0);
        check("R4 set zero no change", {28'd0, out_b}, 32'h3);
        bus_read(3'd4); check("R4 set reads zero", rdata_a, 32'h0);
        bus_read(3'd5); check("R4 clear reads zero", rdata_a, 32'h0); bus_idle();

        // R11: mask readback; also R12 upper bits zero.
        bus_write(3'd2, 32'hFFFF_FFF5);
        bus_read(3'd2); check("R11 mask readback", rdata_b, 32'h5); bus_idle();
        bus_write(3'd2, 32'h0);

        // R5: every old/new pin pair, all three edge kinds.
        for (int o = 0; o < 16; o++) begin
            for (int n = 0; n < 16; n++) begin
                pin_in = o[W-1:0];
                tick(4);
                bus_write(3'd3, 32'hF);
                pin_in = n[W-1:0];
                tick(2);
                bus_read(3'd3);
                check("R5 capture before third edge", rdata_a | rdata_b | rdata_c, 32'h0);
                bus_idle();
                tick(1);
                bus_read(3'd3);
                check("R5 rising capture", rdata_a, 32'(n & ~o & 15));
                check("R5 falling capture", rdata_b, 32'(~n & o & 15));
                check("R5 any capture", rdata_c, 32'((n ^ o) & 15));
                bus_idle();
            end
        end

        // R5: a steady input is captured only once.
        pin_in = 4'h0; tick(4);
        pin_in = 4'hF; tick(4);
        bus_write(3'd3, 32'hF);
        tick(4);
        bus_read(3'd3); check("R5 no recapture", rdata_a | rdata_c, 32'h0); bus_idle();

        // R6 and R7: per-bit clear versus clear-all.
        pin_in = 4'h0; tick(4);
        bus_write(3'd3, 32'hF);
        pin_in = 4'hF; tick(4);
        pin_in = 4'h0; tick(4);
        bus_read(3'd3);
        check("R6 setup A", rdata_a, 32'hF);
        check("R7 setup B", rdata_b, 32'hF);
        bus_idle();
        bus_write(3'd3, 32'h1);
        bus_read(3'd3);
        check("R6 clear bit0 A", rdata_a, 32'hE);
        check("R6 clear bit0 C", rdata_c, 32'hE);
        check("R7 clear all B", rdata_b, 32'h0);
        bus_idle();
        bus_write(3'd3, 32'h4);
        bus_read(3'd3); check("R6 clear bit2 A", rdata_a, 32'hA); bus_idle();

        // R8: edge arrives in the cycle of the clearing write.
        bus_write(3'd3, 32'hF);
        pin_in = 4'h3;
        tick(2);
        addr = 3'd3; wdata = 32'hF; wr = 1'b1;
        tick(1);
        wr = 1'b0; wdata = '0;
        bus_read(3'd3);
        check("R8 rising edge wins A", rdata_a, 32'h3);
        check("R8 any edge wins C", rdata_c, 32'h3);
        check("R8 clear-all without edge B", rdata_b, 32'h0);
        bus_idle();

        // R9: level interrupt over all masks and pin patterns.
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 16; p++) begin
                bus_write(3'd2, 32'(m));
                pin_in = p[W-1:0];
                tick(3);
                check("R9 level irq", {31'd0, irq_b}, {31'd0, |(m & p & 15)});
            end
        end

        // R10: edge interrupt over all masks and rising patterns.
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 16; p++) begin
                pin_in = 4'h0;
                tick(3);
                bus_write(3'd2, 32'(m));
                bus_write(3'd3, 32'hF);
                tick(1);
                check("R10 irq idle", {31'd0, irq_a}, 32'd0);
                pin_in = p[W-1:0];
                tick(3);
                check("R10 irq lags capture", {31'd0, irq_a}, 32'd0);
                tick(1);
                check("R10 edge irq rise", {31'd0, irq_a}, {31'd0, |(m & p & 15)});
                check("R10 edge irq any", {31'd0, irq_c}, {31'd0, |(m & p & 15)});
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule